// File: doc/BRIEF.md
# Load/Store-Multiple Transfer Sequencer

This block carries out one block-transfer instruction, moving a chosen set of 32-bit registers between the register file and memory. On a start strobe it takes the 32-bit instruction word and the current value of the base register. It decodes the direction, the address-update style, the writeback enable, the load/store choice and the user-bank override. It then walks the register list one register at a time, issues one word-aligned memory access per register, and moves the data through a register-file read port (stores) or write port (loads).

The sequencer decides when the updated base value goes back to the register file. A load always writes the base first, so that a value loaded into the base register wins. A store writes the base last only when the base is the lowest-numbered register in the list; otherwise it writes the base first. While the user-bank override is set, a bank-select output stays high for every register access of the transfer. It drops when the transfer ends. Completion is signalled by a one-cycle done pulse.

Top module: `blkxfer_seq`

## Requirements
- R1: Instruction word fields: bits 19..16 give the base register index and bits 15..0 give the register list. Within the class byte (bits 27..20), bit 20 selects load (1) or store (0), bit 21 enables base writeback, bit 22 is the user-bank flag, bit 23 selects increment (1) or decrement (0), and bit 24 selects pre-update (1) or post-update (0).
- R2: Every memory address has its two low bits cleared, taken from the base value with bits 1..0 forced to zero. Successive accesses differ by +4 when incrementing and by -4 when decrementing.
- R3: Registers are transferred in ascending index order when incrementing and in descending order when decrementing. Clear list bits produce no access.
- R4: In pre-update mode the first access is at the aligned base plus or minus 4. In post-update mode the first access is at the aligned base.
- R5: The number of accesses equals the number of set list bits. With writeback, the base register ends at the unaligned base plus or minus 4 times that number.
- R6: A load with writeback writes the final base before any transfer, so a value loaded into the base register overrides it.
- R7: A store with writeback writes the base only after all transfers when the base register is the lowest set bit of the list, so the original base is stored. Otherwise it writes the base before the transfers, so the updated base is stored.
- R8: A store of register 15 puts the register-file value of register 15 plus 4 on the write data bus.
- R9: When the user-bank flag is set, rf_user_bank is high for the whole transfer, including every register read and write. It is low whenever the sequencer is idle.
- R10: A memory request holds its address and data until mem_ready. Only one access is outstanding at a time. Load data is taken on mem_rvalid and written to the listed register.
- R11: done is a single-cycle pulse that follows the last transfer and any final writeback.
- R12: With an empty register list there is no memory access and no register write, and done is high in the cycle after start.
- R13: With writeback disabled, the base register keeps its value unless it is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer (taken when idle) |
| instr | input | 32 | Instruction word |
| base_val | input | 32 | Current value of the base register |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write (store), 0 = read (load) |
| mem_addr | output | 32 | Word-aligned access address |
| mem_wdata | output | 32 | Store data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Load data valid |
| mem_rdata | input | 32 | Load data |
| rf_rd_idx | output | 4 | Register-file read index |
| rf_rd_data | input | 32 | Register-file read data |
| rf_we | output | 1 | Register-file write enable |
| rf_wr_idx | output | 4 | Register-file write index |
| rf_wr_data | output | 32 | Register-file write data |
| rf_user_bank | output | 1 | Route register accesses to the user bank |

## Verification
The hardest case to reach is a store in which the base register is itself in the list. Whether memory receives the original or the updated base then depends only on whether the base is the lowest set bit. This difference shows up solely in the stored data word, not in the addresses. The stimulus builds two stores that differ only in which register is the base: one with the base below every other listed register, and one with a lower register also listed. The bench compares each stored word against a register-file model that applies the writeback at the required moment. Loads that name the base register, with stalls on the memory handshake, cover the load-side override.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WBPRE,
    ST_RD,
    ST_LAUNCH,
    ST_REQ,
    ST_WAIT,
    ST_FIN
  } seq_state_e;

  typedef struct packed {
    logic pre;
    logic inc;
    logic user;
    logic wb;
    logic is_load;
  } xfer_mode_t;

endpackage

// File: rtl/blkxfer_decode.sv
module blkxfer_decode
  import blkxfer_pkg::*;
#(
  parameter int NREGS  = 16,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(NREGS),
  localparam int CNT_W = $clog2(NREGS + 1)
) (
  input  logic [31:0]       instr,
  input  logic [DATA_W-1:0] base_val,
  output xfer_mode_t        mode,
  output logic [IDX_W-1:0]  base_idx,
  output logic [NREGS-1:0]  list,
  output logic [CNT_W-1:0]  count,
  output logic [DATA_W-1:0] final_base,
  output logic              wb_early
);

  logic [NREGS-1:0]  below_mask;
  logic [DATA_W-1:0] span;
  logic              base_in_list;
  logic              base_lowest;

  always_comb begin
    mode.is_load = instr[20];
    mode.wb      = instr[21];
    mode.user    = instr[22];
    mode.inc     = instr[23];
    mode.pre     = instr[24];
    base_idx     = instr[16 +: IDX_W];
    list         = instr[NREGS-1:0];
  end

  always_comb begin
    count = '0;
    for (int i = 0; i < NREGS; i++) begin
      count = count + CNT_W'(list[i]);
    end
  end

  always_comb begin
    span       = DATA_W'(count) << 2;
    final_base = mode.inc ? (base_val + span) : (base_val - span);
  end

  always_comb begin
    below_mask   = (NREGS'(1) << base_idx) - NREGS'(1);
    base_in_list = list[base_idx];
    base_lowest  = ((list & below_mask) == '0);
    wb_early     = mode.is_load || !(base_in_list && base_lowest);
  end

endmodule

// File: rtl/blkxfer_pick.sv
module blkxfer_pick #(
  parameter int NREGS = 16,
  localparam int IDX_W = $clog2(NREGS)
) (
  input  logic [NREGS-1:0] mask,
  input  logic             descending,
  output logic [IDX_W-1:0] idx,
  output logic             any
);

  logic [IDX_W-1:0] lo_idx;
  logic [IDX_W-1:0] hi_idx;

  always_comb begin
    lo_idx = '0;
    for (int i = NREGS - 1; i >= 0; i--) begin
      if (mask[i]) lo_idx = IDX_W'(i);
    end
  end

  always_comb begin
    hi_idx = '0;
    for (int i = 0; i < NREGS; i++) begin
      if (mask[i]) hi_idx = IDX_W'(i);
    end
  end

  assign idx = descending ? hi_idx : lo_idx;
  assign any = |mask;

endmodule

// File: rtl/blkxfer_addr.sv
module blkxfer_addr #(
  parameter int ADDR_W = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init,
  input  logic [ADDR_W-1:0] base,
  input  logic              inc_in,
  input  logic              pre_in,
  input  logic              step,
  output logic [ADDR_W-1:0] addr
);

  localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(WORD_BYTES);
  localparam int                LOW_W  = $clog2(WORD_BYTES);

  logic              inc_q;
  logic [ADDR_W-1:0] aligned;
  logic [ADDR_W-1:0] first;

  always_comb begin
    aligned = {base[ADDR_W-1:LOW_W], {LOW_W{1'b0}}};
    if (!pre_in)     first = aligned;
    else if (inc_in) first = aligned + STRIDE;
    else             first = aligned - STRIDE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr  <= '0;
      inc_q <= 1'b0;
    end else if (init) begin
      addr  <= first;
      inc_q <= inc_in;
    end else if (step) begin
      addr <= inc_q ? (addr + STRIDE) : (addr - STRIDE);
    end
  end

endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
  import blkxfer_pkg::*;
#(
  parameter int NREGS   = 16,
  parameter int DATA_W  = 32,
  parameter int PC_BIAS = 4,
  localparam int IDX_W  = $clog2(NREGS),
  localparam int CNT_W  = $clog2(NREGS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [31:0]       instr,
  input  logic [DATA_W-1:0] base_val,
  output logic              busy,
  output logic              done,
  output logic              mem_req,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [IDX_W-1:0]  rf_rd_idx,
  input  logic [DATA_W-1:0] rf_rd_data,
  output logic              rf_we,
  output logic [IDX_W-1:0]  rf_wr_idx,
  output logic [DATA_W-1:0] rf_wr_data,
  output logic              rf_user_bank
);

  localparam logic [IDX_W-1:0] PC_IDX = IDX_W'(NREGS - 1);

  seq_state_e        state;
  xfer_mode_t        dec_mode, mode_q;
  logic [IDX_W-1:0]  dec_base_idx, base_idx_q;
  logic [NREGS-1:0]  dec_list, mask_q, mask_rest;
  logic [CNT_W-1:0]  dec_count;
  logic [DATA_W-1:0] dec_final, final_q;
  logic              dec_wb_early, late_wb_q;
  logic [IDX_W-1:0]  pick_idx, cur_idx;
  logic              pick_any;
  logic              addr_init, addr_step;
  logic [DATA_W-1:0] cur_addr;
  logic              accept;

  blkxfer_decode #(.NREGS(NREGS), .DATA_W(DATA_W)) u_decode (
    .instr      (instr),
    .base_val   (base_val),
    .mode       (dec_mode),
    .base_idx   (dec_base_idx),
    .list       (dec_list),
    .count      (dec_count),
    .final_base (dec_final),
    .wb_early   (dec_wb_early)
  );

  blkxfer_pick #(.NREGS(NREGS)) u_pick (
    .mask       (mask_q),
    .descending (!mode_q.inc),
    .idx        (pick_idx),
    .any        (pick_any)
  );

  blkxfer_addr #(.ADDR_W(DATA_W), .WORD_BYTES(4)) u_addr (
    .clk    (clk),
    .rst    (rst),
    .init   (addr_init),
    .base   (base_val),
    .inc_in (dec_mode.inc),
    .pre_in (dec_mode.pre),
    .step   (addr_step),
    .addr   (cur_addr)
  );

  assign addr_init = (state == ST_IDLE) && start;
  assign accept    = (state == ST_REQ) && mem_req && mem_ready;
  assign addr_step = accept;
  assign mask_rest = mask_q & ~(NREGS'(1) << cur_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      mode_q       <= '0;
      base_idx_q   <= '0;
      mask_q       <= '0;
      final_q      <= '0;
      late_wb_q    <= 1'b0;
      cur_idx      <= '0;
      busy         <= 1'b0;
      done         <= 1'b0;
      mem_req      <= 1'b0;
      mem_we       <= 1'b0;
      mem_addr     <= '0;
      mem_wdata    <= '0;
      rf_rd_idx    <= '0;
      rf_we        <= 1'b0;
      rf_wr_idx    <= '0;
      rf_wr_data   <= '0;
      rf_user_bank <= 1'b0;
    end else begin
      done  <= 1'b0;
      rf_we <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            mode_q     <= dec_mode;
            base_idx_q <= dec_base_idx;
            mask_q     <= dec_list;
            final_q    <= dec_final;
            late_wb_q  <= dec_mode.wb && !dec_wb_early;
            if (dec_count == '0) begin
              done <= 1'b1;
            end else begin
              busy         <= 1'b1;
              rf_user_bank <= dec_mode.user;
              if (dec_mode.wb && dec_wb_early) begin
                rf_we      <= 1'b1;
                rf_wr_idx  <= dec_base_idx;
                rf_wr_data <= dec_final;
                state      <= ST_WBPRE;
              end else begin
                state <= ST_RD;
              end
            end
          end
        end
        ST_WBPRE: state <= ST_RD;
        ST_RD: begin
          rf_rd_idx <= pick_idx;
          cur_idx   <= pick_idx;
          state     <= ST_LAUNCH;
        end
        ST_LAUNCH: begin
          mem_req   <= 1'b1;
          mem_we    <= !mode_q.is_load;
          mem_addr  <= cur_addr;
          mem_wdata <= (cur_idx == PC_IDX) ? (rf_rd_data + DATA_W'(PC_BIAS))
                                           : rf_rd_data;
          state     <= ST_REQ;
        end
        ST_REQ: begin
          if (mem_ready) begin
            mem_req <= 1'b0;
            mask_q  <= mask_rest;
            if (mode_q.is_load) begin
              state <= ST_WAIT;
            end else if (mask_rest != '0) begin
              state <= ST_RD;
            end else begin
              if (late_wb_q) begin
                rf_we      <= 1'b1;
                rf_wr_idx  <= base_idx_q;
                rf_wr_data <= final_q;
              end
              state <= ST_FIN;
            end
          end
        end
        ST_WAIT: begin
          if (mem_rvalid) begin
            rf_we      <= 1'b1;
            rf_wr_idx  <= cur_idx;
            rf_wr_data <= mem_rdata;
            state      <= (mask_q != '0) ? ST_RD : ST_FIN;
          end
        end
        ST_FIN: begin
          done         <= 1'b1;
          busy         <= 1'b0;
          rf_user_bank <= 1'b0;
          state        <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_we)));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R2
  addr_align_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  // R9
  bank_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !rf_user_bank);

  // R12
  empty_list_chk: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_IDLE) && start && (dec_list == '0)) |=> (done && !mem_req && !rf_we && !busy));

  // R10
  rf_write_busy_chk: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> busy);

  // R10
  pick_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RD) |-> pick_any);

endmodule

// File: tb/blkxfer_seq_tb.sv
module blkxfer_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] base_val = '0;
  logic        busy, done, mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ready;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [3:0]  rf_rd_idx;
  logic [31:0] rf_rd_data;
  logic        rf_we;
  logic [3:0]  rf_wr_idx;
  logic [31:0] rf_wr_data;
  logic        rf_user_bank;

  always #10 clk = ~clk;

  blkxfer_seq dut_i (
    .clk(clk), .rst(rst), .start(start), .instr(instr), .base_val(base_val),
    .busy(busy), .done(done), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .rf_rd_idx(rf_rd_idx),
    .rf_rd_data(rf_rd_data), .rf_we(rf_we), .rf_wr_idx(rf_wr_idx),
    .rf_wr_data(rf_wr_data), .rf_user_bank(rf_user_bank)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [31:0] regs [16];
  logic [31:0] mem  [64];
  logic        stall_en = 1'b0;
  logic        gate = 1'b0;
  logic        exp_user = 1'b0;
  int          bank_bad = 0;
  int          log_n = 0;
  logic [31:0] log_addr [32];
  logic        log_we   [32];
  logic [31:0] log_data [32];

  logic [31:0] e_regs [16];
  logic [31:0] e_mem  [64];
  int          e_n;
  logic [31:0] e_addr [32];
  logic        e_we   [32];
  logic [31:0] e_data [32];

  assign rf_rd_data = regs[rf_rd_idx];
  assign mem_ready  = mem_req && (!stall_en || gate);

  always @(posedge clk) begin
    gate       <= ~gate;
    mem_rvalid <= 1'b0;
    if (rf_we) regs[rf_wr_idx] <= rf_wr_data;
    if (busy && (rf_user_bank !== exp_user)) bank_bad <= bank_bad + 1;
    if (!busy && rf_user_bank) bank_bad <= bank_bad + 1;
    if (mem_req && mem_ready) begin
      if (log_n < 32) begin
        log_addr[log_n] <= mem_addr;
        log_we[log_n]   <= mem_we;
        log_data[log_n] <= mem_we ? mem_wdata : mem[mem_addr[7:2]];
      end
      log_n <= log_n + 1;
      if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
      else begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem[mem_addr[7:2]];
      end
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected < 150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Reference: class byte bit0 load, bit1 writeback, bit2 user, bit3 inc, bit4 pre.
  task automatic compute_exp(logic [7:0] cls, int rn, logic [15:0] lst);
    logic [31:0] a, fin;
    int n;
    logic ld, wb, inc, pre, first;
    ld = cls[0]; wb = cls[1]; inc = cls[3]; pre = cls[4];
    for (int i = 0; i < 16; i++) e_regs[i] = regs[i];
    for (int i = 0; i < 64; i++) e_mem[i] = mem[i];
    n = 0;
    for (int i = 0; i < 16; i++) if (lst[i]) n++;
    fin = inc ? regs[rn] + 32'(4 * n) : regs[rn] - 32'(4 * n);
    a = {regs[rn][31:2], 2'b00};
    first = 1'b1;
    for (int i = 0; i < rn; i++) if (lst[i]) first = 1'b0;
    first = first && lst[rn];
    e_n = 0;
    if (n == 0) return;
    if (wb && (ld || !first)) e_regs[rn] = fin;
    for (int k = 0; k < 16; k++) begin
      int r;
      r = inc ? k : 15 - k;
      if (lst[r]) begin
        if (pre) a = inc ? a + 4 : a - 4;
        e_addr[e_n] = a;
        e_we[e_n]   = !ld;
        if (ld) begin
          e_data[e_n] = e_mem[a[7:2]];
          e_regs[r]   = e_mem[a[7:2]];
        end else begin
          e_data[e_n] = (r == 15) ? e_regs[15] + 4 : e_regs[r];
          e_mem[a[7:2]] = e_data[e_n];
        end
        e_n++;
        if (!pre) a = inc ? a + 4 : a - 4;
      end
    end
    if (wb && !ld && first) e_regs[rn] = fin;
  endtask

  task automatic prep(int rn, logic [31:0] bv);
    for (int i = 0; i < 16; i++) regs[i] = 32'h1000_0000 + 32'(i * 32'h10101);
    regs[15] = 32'h0000_2000;
    regs[rn] = bv;
    for (int i = 0; i < 64; i++) mem[i] = 32'hA500_0000 + 32'(i * 32'h111);
  endtask

  task automatic run_xfer(string tag, logic [7:0] cls, int rn, logic [15:0] lst,
                          logic [31:0] bv, logic stall);
    int wait_cyc;
    prep(rn, bv);
    compute_exp(cls, rn, lst);
    stall_en = stall;
    exp_user = cls[2];
    bank_bad = 0;
    log_n    = 0;
    @(negedge clk);
    instr    = {4'hE, cls, 4'(rn), lst};
    base_val = regs[rn];
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (lst == 16'h0) chk({tag, " done next cycle"}, 32'(done), 32'd1);
    wait_cyc = 0;
    while (!done && wait_cyc < 2000) begin
      @(negedge clk);
      wait_cyc++;
    end
    chk({tag, " done seen"}, 32'(done), 32'd1);
    @(negedge clk);
    chk({tag, " done single pulse R11"}, 32'(done), 32'd0);
    chk({tag, " access count"}, 32'(log_n), 32'(e_n));
    for (int i = 0; i < e_n && i < 32; i++) begin
      chk($sformatf("%s addr #%0d", tag, i), log_addr[i], e_addr[i]);
      chk($sformatf("%s write flag #%0d", tag, i), 32'(log_we[i]), 32'(e_we[i]));
      chk($sformatf("%s data #%0d", tag, i), log_data[i], e_data[i]);
    end
    for (int i = 0; i < 16; i++) chk($sformatf("%s reg %0d", tag, i), regs[i], e_regs[i]);
    begin
      int bad;
      bad = 0;
      for (int i = 0; i < 64; i++) if (mem[i] !== e_mem[i]) bad++;
      chk({tag, " memory words differing"}, 32'(bad), 32'd0);
    end
    chk({tag, " bank select R9"}, 32'(bank_bad), 32'd0);
    chk({tag, " idle bank R9"}, 32'(rf_user_bank), 32'd0);
  endtask

  task automatic t_reset();
    chk("R11 reset done", 32'(done), 0);
    chk("R10 reset mem_req", 32'(mem_req), 0);
    chk("R10 reset rf_we", 32'(rf_we), 0);
    chk("R9 reset bank", 32'(rf_user_bank), 0);
  endtask

  // R1 R5 R6: load, inc, post, writeback, unaligned base
  task automatic t_load_inc_wb();   run_xfer("R1/R5/R6 load inc post wb", 8'h8B, 13, 16'h00F2, 32'h0000_0041, 1'b0); endtask
  // R3 R8 R2: store, dec, pre, wb, includes r15, stalls
  task automatic t_store_dec_pc();  run_xfer("R3/R8/R2 store dec pre wb", 8'h92, 13, 16'hC00F, 32'h0000_00C0, 1'b1); endtask
  // R4 R13: store, inc, pre, no wb
  task automatic t_store_inc_pre(); run_xfer("R4/R13 store inc pre", 8'h98, 3, 16'h0A21, 32'h0000_0022, 1'b0); endtask
  // R3 R13: load, dec, post, no wb, stalls
  task automatic t_load_dec_post(); run_xfer("R3/R13 load dec post", 8'h81, 13, 16'h1300, 32'h0000_00A0, 1'b1); endtask
  // R6: load with writeback, base in list
  task automatic t_load_base_in();  run_xfer("R6 load base in list", 8'h8B, 2, 16'h0006, 32'h0000_0010, 1'b1); endtask
  // R7: store wb, base lowest in list
  task automatic t_store_base_lo(); run_xfer("R7 store base lowest", 8'h8A, 1, 16'h0016, 32'h0000_0030, 1'b0); endtask
  // R7: store wb, base not lowest
  task automatic t_store_base_hi(); run_xfer("R7 store base not lowest", 8'h8A, 4, 16'h0013, 32'h0000_0030, 1'b0); endtask
  // R9: user bank on load and store
  task automatic t_user_bank();
    run_xfer("R9 user load", 8'h8F, 5, 16'h00C3, 32'h0000_0040, 1'b1);
    run_xfer("R9 user store", 8'h9E, 6, 16'h8101, 32'h0000_0050, 1'b0);
  endtask
  // R12: empty list
  task automatic t_empty();          run_xfer("R12 empty list", 8'h8B, 7, 16'h0000, 32'h0000_0044, 1'b0); endtask
  // R5 R10: full list store, stalls
  task automatic t_full();           run_xfer("R5/R10 full list", 8'h8A, 0, 16'hFFFF, 32'h0000_0004, 1'b1); endtask

  initial begin
    prep(0, 32'h0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_load_inc_wb();
    t_store_dec_pc();
    t_store_inc_pre();
    t_load_dec_post();
    t_load_base_in();
    t_store_base_lo();
    t_store_base_hi();
    t_user_bank();
    t_empty();
    t_full();
    summary();
    $finish;
  end

endmodule